// File: doc/BRIEF.md
# Oversampled Serial Receiver with Bus Read Port

This block receives asynchronous serial characters on a single line and presents each assembled byte to a processor through an active-low read strobe. All timing comes from one clock running at sixteen times the bit rate. Each frame has a low start bit, eight data bits sent least significant bit first, one parity bit and one high stop bit.

The serial input first passes through a two-flop synchronizer. A dedicated edge detector then watches for a falling edge. The line must stay low for half a bit period before the start bit is accepted. If it does not, the receiver goes back to searching. Once the start bit is accepted, a 4-bit phase counter places one sample at the centre of every following bit. Parity is accumulated as each data bit is shifted in. When the stop bit is sampled, the byte is committed and the data-ready, parity, overrun and framing flags are updated.

A processor reads the byte by pulling the read strobe low. On the falling edge of the strobe the stored byte is loaded onto the output bus. On the rising edge the ready flag and all error flags are cleared.

Top module: `uart_rx_bus`

## Requirements
- R1: After reset, `dataOut` is 0 and `dataReady`, `parityErr`, `overrunErr` and `framingErr` are all 0.
- R2: A falling edge on `serialIn` starts a frame only if the synchronized line stays low for 8 consecutive clocks, counting from the first low clock. A low pulse of 7 clocks or fewer produces no byte and changes no flag.
- R3: Each bit lasts 16 clocks. Data bits are sampled at mid-bit and assembled least significant bit first, so bit 0 of `dataOut` is the first data bit after the start bit.
- R4: With `ODD_PARITY`=0, the parity bit makes the total count of ones in the data and parity bits even. With `ODD_PARITY`=1, it makes that count odd. A mismatch sets `parityErr` when the byte completes.
- R5: If the stop bit, sampled at its centre, is 0, `framingErr` is set when the byte completes. The byte is still stored.
- R6: If a byte completes while `dataReady` is still 1 from an unread byte, `overrunErr` is set and the new byte replaces the old one.
- R7: On a falling edge of `rdN`, the stored byte appears on `dataOut` one clock later. Otherwise `dataOut` holds its value.
- R8: On a rising edge of `rdN`, `dataReady` and the three error flags clear on the next clock.
- R9: `dataReady` rises on the 170th rising clock edge after `serialIn` falls for the start bit. This count is made of 2 edges of synchronizer, 8 of start qualification and 160 to the stop-bit centre.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at 16x the bit rate |
| rstN | input | 1 | Active-low asynchronous reset |
| serialIn | input | 1 | Asynchronous serial line, idle high |
| rdN | input | 1 | Active-low read strobe, synchronous to `clk` |
| dataOut | output | DATA_BITS | Byte loaded on a read-strobe falling edge |
| dataReady | output | 1 | A received byte is waiting to be read |
| parityErr | output | 1 | Parity mismatch on the stored byte |
| overrunErr | output | 1 | An unread byte was overwritten |
| framingErr | output | 1 | Stop bit of the stored byte was sampled low |

## Verification
The bench sends a 7-clock low pulse, one clock short of qualification. A receiver that accepted any falling edge would then clock in a phantom byte of ones. It checks the exact cycle on which `dataReady` rises, which exposes an off-by-one in the synchronizer, the qualification count or the centre-sampling phase. Reversed bit order shows up in the asymmetric patterns. Frames with a flipped parity bit, a low stop bit and two back-to-back unread bytes confirm that each flag fires alone and that the newer byte wins. After every read it also confirms that the flags clear and the bus holds its value.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rxState_t;

  // Single-cycle strobes from control to datapath
  typedef struct packed {
    logic clrPar;     // start bit accepted: reset running parity
    logic shiftBit;   // mid-bit of a data bit: shift sample in
    logic parCheck;   // mid-bit of parity bit: compare
    logic stopCheck;  // mid-bit of stop bit: commit byte and flags
  } rxStrobe_t;

endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sIn,
  input  logic      fallEdge,
  output rxStrobe_t strobe
);

  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int HALF  = OVERSAMPLE / 2;
  localparam int BIT_W = $clog2(DATA_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_PHASE = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] QUAL_PHASE = CNT_W'(HALF - 1);
  localparam logic [BIT_W-1:0] LAST_BIT   = BIT_W'(DATA_BITS - 1);

  rxState_t         state;
  logic [CNT_W-1:0] phase;
  logic [BIT_W-1:0] bitIdx;
  logic             phaseEnd;

  assign phaseEnd = (phase == LAST_PHASE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phase  <= '0;
      bitIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (fallEdge) begin
            state <= ST_START;
            phase <= CNT_W'(1);  // the edge cycle itself counts as one low
          end
        end
        ST_START: begin
          if (sIn) begin
            state <= ST_IDLE;
            phase <= '0;
          end else if (phase == QUAL_PHASE) begin
            state  <= ST_DATA;
            phase  <= '0;
            bitIdx <= '0;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        ST_DATA: begin
          if (phaseEnd) begin
            phase  <= '0;
            bitIdx <= bitIdx + 1'b1;
            if (bitIdx == LAST_BIT) state <= ST_PARITY;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        ST_PARITY: begin
          if (phaseEnd) begin
            phase <= '0;
            state <= ST_STOP;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        ST_STOP: begin
          if (phaseEnd) begin
            phase <= '0;
            state <= ST_IDLE;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        default: begin
          state <= ST_IDLE;
          phase <= '0;
        end
      endcase
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.clrPar    = (state == ST_START) && !sIn && (phase == QUAL_PHASE);
    strobe.shiftBit  = (state == ST_DATA)   && phaseEnd;
    strobe.parCheck  = (state == ST_PARITY) && phaseEnd;
    strobe.stopCheck = (state == ST_STOP)   && phaseEnd;
  end

  // R2: a line that returns high during qualification aborts the frame
  p_glitch_abort_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && sIn) |=> (state == ST_IDLE));

  // R3: strobes never overlap
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.clrPar, strobe.shiftBit, strobe.parCheck, strobe.stopCheck}));

  // R3: exactly DATA_BITS samples were shifted before parity
  p_bit_count_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PARITY) |-> (bitIdx == BIT_W'(DATA_BITS)));

  // R2: idle is left only on a detected falling edge
  p_idle_wait_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !fallEdge) |=> (state == ST_IDLE));

endmodule

// File: rtl/uart_rx_dp.sv
module uart_rx_dp
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter bit ODD_PARITY = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serialIn,
  input  logic                 rdN,
  input  rxStrobe_t            strobe,
  output logic                 sIn,
  output logic                 fallEdge,
  output logic [DATA_BITS-1:0] dataOut,
  output logic                 dataReady,
  output logic                 parityErr,
  output logic                 overrunErr,
  output logic                 framingErr
);

  logic                 syncA, syncB, sPrev;
  logic [DATA_BITS-1:0] shiftReg, rxByte;
  logic                 runPar, parBad;
  logic                 rdPrev, rdFall, rdRise;

  // Two-flop synchronizer and edge detector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
      sPrev <= 1'b1;
    end else begin
      syncA <= serialIn;
      syncB <= syncA;
      sPrev <= syncB;
    end
  end

  assign sIn      = syncB;
  assign fallEdge = sPrev & ~syncB;

  // Shift register (LSB first) and running parity
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      runPar   <= 1'b0;
      parBad   <= 1'b0;
    end else begin
      if (strobe.clrPar) runPar <= 1'b0;
      if (strobe.shiftBit) begin
        shiftReg <= {syncB, shiftReg[DATA_BITS-1:1]};
        runPar   <= runPar ^ syncB;
      end
      if (strobe.parCheck) parBad <= runPar ^ syncB ^ ODD_PARITY;
    end
  end

  // Read strobe edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdPrev <= 1'b1;
    else       rdPrev <= rdN;
  end

  assign rdFall = rdPrev & ~rdN;
  assign rdRise = ~rdPrev & rdN;

  // Holding register, bus output and flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte     <= '0;
      dataOut    <= '0;
      dataReady  <= 1'b0;
      parityErr  <= 1'b0;
      overrunErr <= 1'b0;
      framingErr <= 1'b0;
    end else begin
      if (rdFall) dataOut <= rxByte;
      if (strobe.stopCheck) begin
        rxByte     <= shiftReg;
        dataReady  <= 1'b1;
        overrunErr <= dataReady & ~rdRise;
        parityErr  <= parBad;
        framingErr <= ~syncB;
      end else if (rdRise) begin
        dataReady  <= 1'b0;
        parityErr  <= 1'b0;
        overrunErr <= 1'b0;
        framingErr <= 1'b0;
      end
    end
  end

  // R9: a committed byte always raises ready
  p_ready_after_stop_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stopCheck |=> dataReady);

  // R5: framing flag follows the sampled stop bit
  p_framing_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stopCheck && !syncB) |=> framingErr);

  // R6: completing over an unread byte flags overrun
  p_overrun_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stopCheck && dataReady && !rdRise) |=> overrunErr);

  // R8: strobe release clears all flags
  p_release_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdRise && !strobe.stopCheck) |=>
      (!dataReady && !parityErr && !overrunErr && !framingErr));

  // R7: bus only changes on a read-strobe falling edge
  p_bus_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !rdFall |=> $stable(dataOut));

endmodule

// File: rtl/uart_rx_bus.sv
module uart_rx_bus
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8,
  parameter bit ODD_PARITY = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serialIn,
  input  logic                 rdN,
  output logic [DATA_BITS-1:0] dataOut,
  output logic                 dataReady,
  output logic                 parityErr,
  output logic                 overrunErr,
  output logic                 framingErr
);

  rxStrobe_t strobe;
  logic      sIn;
  logic      fallEdge;

  uart_rx_ctrl #(
    .OVERSAMPLE(OVERSAMPLE),
    .DATA_BITS (DATA_BITS)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .sIn     (sIn),
    .fallEdge(fallEdge),
    .strobe  (strobe)
  );

  uart_rx_dp #(
    .DATA_BITS (DATA_BITS),
    .ODD_PARITY(ODD_PARITY)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .serialIn  (serialIn),
    .rdN       (rdN),
    .strobe    (strobe),
    .sIn       (sIn),
    .fallEdge  (fallEdge),
    .dataOut   (dataOut),
    .dataReady (dataReady),
    .parityErr (parityErr),
    .overrunErr(overrunErr),
    .framingErr(framingErr)
  );

endmodule

// File: tb/uart_rx_bus_tb_top.sv
module uart_rx_bus_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 16;

  typedef struct {
    logic [7:0] val;
    bit         pe;
    bit         fe;
    bit         oe;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serialIn = 1'b1;
  logic       rdN = 1'b1;
  logic [7:0] dataOut;
  logic       dataReady, parityErr, overrunErr, framingErr;

  expItem_t expQ[$];
  int  compared = 0;
  int  mismatched = 0;
  bit  autoRead = 1'b0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_bus dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .serialIn  (serialIn),
    .rdN       (rdN),
    .dataOut   (dataOut),
    .dataReady (dataReady),
    .parityErr (parityErr),
    .overrunErr(overrunErr),
    .framingErr(framingErr)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // Driver: one frame, expected result pushed when wanted
  task automatic sendFrame(input logic [7:0] val, input bit flipPar, input bit badStop,
                           input bit push, input bit oe, input bit measure);
    logic parBit;
    expItem_t it;
    parBit = (^val) ^ flipPar;  // even parity
    if (push) begin
      it.val = val; it.pe = flipPar; it.fe = badStop; it.oe = oe;
      expQ.push_back(it);
    end
    @(negedge clk);
    serialIn = 1'b0;
    if (measure) begin
      fork
        begin
          repeat (169) @(negedge clk);
          chk({31'd0, dataReady}, 32'd0, "R9 ready before edge 170");
          @(negedge clk);
          chk({31'd0, dataReady}, 32'd1, "R9 ready at edge 170");
        end
      join_none
    end
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      serialIn = val[i];
      repeat (BIT_CLKS) @(negedge clk);
    end
    serialIn = parBit;
    repeat (BIT_CLKS) @(negedge clk);
    serialIn = ~badStop;
    repeat (BIT_CLKS) @(negedge clk);
    serialIn = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  // Read through the bus and compare against the scoreboard head
  task automatic readAndCompare();
    expItem_t it;
    logic [7:0] held;
    rdN = 1'b0;
    @(negedge clk);
    if (expQ.size() == 0) begin
      chk(32'd1, 32'd0, "R2 unexpected byte");
    end else begin
      it = expQ.pop_front();
      chk({24'd0, dataOut}, {24'd0, it.val}, "R3/R7 byte value");
      chk({31'd0, parityErr}, {31'd0, it.pe}, "R4 parity flag");
      chk({31'd0, framingErr}, {31'd0, it.fe}, "R5 framing flag");
      chk({31'd0, overrunErr}, {31'd0, it.oe}, "R6 overrun flag");
    end
    held = dataOut;
    rdN = 1'b1;
    @(negedge clk);
    chk({28'd0, dataReady, parityErr, overrunErr, framingErr}, 32'd0, "R8 flags cleared");
    @(negedge clk);
    chk({24'd0, dataOut}, {24'd0, held}, "R7 bus holds after read");
  endtask

  // Monitor
  initial begin
    forever begin
      @(negedge clk);
      if (autoRead && dataReady && !finished) readAndCompare();
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({24'd0, dataOut}, 32'd0, "R1 dataOut reset");
    chk({31'd0, dataReady}, 32'd0, "R1 dataReady reset");
    chk({31'd0, parityErr}, 32'd0, "R1 parityErr reset");
    chk({31'd0, overrunErr}, 32'd0, "R1 overrunErr reset");
    chk({31'd0, framingErr}, 32'd0, "R1 framingErr reset");
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    autoRead = 1'b1;

    // R3 / R9: plain frames, asymmetric patterns
    sendFrame(8'hA5, 0, 0, 1, 0, 1);
    sendFrame(8'h01, 0, 0, 1, 0, 0);
    sendFrame(8'h80, 0, 0, 1, 0, 0);
    sendFrame(8'h00, 0, 0, 1, 0, 0);
    sendFrame(8'hFF, 0, 0, 1, 0, 0);
    sendFrame(8'h3C, 0, 0, 1, 0, 0);

    // R2: 7-clock low pulse must be rejected
    @(negedge clk);
    serialIn = 1'b0;
    repeat (7) @(negedge clk);
    serialIn = 1'b1;
    repeat (200) @(negedge clk);
    chk({31'd0, dataReady}, 32'd0, "R2 short pulse no byte");
    chk({28'd0, dataReady, parityErr, overrunErr, framingErr}, 32'd0, "R2 short pulse no flags");

    // R4: flipped parity bit
    sendFrame(8'h5A, 1, 0, 1, 0, 0);
    // R5: low stop bit
    sendFrame(8'hC3, 0, 1, 1, 0, 0);
    // Back to normal after errors
    sendFrame(8'h96, 0, 0, 1, 0, 0);

    // R6: two unread bytes, newer one wins
    repeat (10) @(negedge clk);
    autoRead = 1'b0;
    sendFrame(8'h11, 0, 0, 0, 0, 0);
    sendFrame(8'h7E, 0, 0, 1, 1, 0);
    chk({31'd0, dataReady}, 32'd1, "R6 ready before read");
    readAndCompare();

    repeat (50) @(negedge clk);
    chk(expQ.size(), 32'd0, "R2 all expected bytes delivered");
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule